// File: doc/BRIEF.md
# Banked Register Operand Collector

This block fetches the source operands of one instruction from a register file that is split into four single-ported banks, 32 bits wide. A register lives in the bank given by the low two bits of its index. The row inside that bank is given by the remaining upper bits. An instruction names up to three source slots, and each slot has its own enable. The collector reads every bank that holds a wanted register in the same cycle. When two or more distinct wanted registers share a bank, it reads them in successive cycles. As a result, the time to gather the operands depends on how the instruction's registers fall across the banks.

A caller presents a request when `req_ready` is high. The collector then stays busy until every enabled slot has been captured. It raises `opnd_valid` for one cycle with the operands placed in their slot order. A slot that repeats an index already named by an earlier enabled slot costs no extra read. A profiling counter adds one for every cycle lost to a bank conflict. The register contents are loaded through a simple write port.

Top module: `opnd_collector`

## Requirements
- R1: Register index i is stored in bank i mod 4 at row i div 4. A value written through the write port to index i is the operand later returned for any enabled slot that names i.
- R2: Each of the three slots has an enable bit (bit s of `req_en` belongs to slot s). A slot whose enable bit is low returns zero and causes no read.
- R3: Each bank delivers at most one register per cycle. With N = max(1, the largest number of distinct enabled indices that share one bank), `opnd_valid` is high during the cycle that begins N edges after the accepting edge. Three distinct registers in one bank therefore take three read cycles.
- R4: When every enabled slot names a different bank, all reads finish in one cycle, and `opnd_valid` is high in the second cycle after acceptance.
- R5: When an enabled slot repeats the index of an earlier enabled slot, that index is read only once and both slots return the same value.
- R6: `req_ready` is low from the accepting edge until the edge at which `opnd_valid` rises. A request offered while `req_ready` is low is ignored: it produces no later result and does not change the result in progress.
- R7: `conflict_cnt` increases by N-1 for each collected instruction and holds its value while the collector is idle.
- R8: Slot s of the instruction is presented on `opnd_data[32*s+31:32*s]`, whatever order the banks were read in.
- R9: After reset `req_ready` is high, `opnd_valid` is low and `conflict_cnt` is zero.
- R10: `opnd_valid` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 6 | Register index to write |
| wr_data | input | 32 | Data to write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Collector idle, request will be taken |
| req_idx | input | 18 | Source indices, slot s at bits 6s+5:6s |
| req_en | input | 3 | Per-slot enable |
| opnd_valid | output | 1 | Operands ready, one-cycle pulse |
| opnd_data | output | 96 | Operands in slot order |
| conflict_cnt | output | 16 | Cycles lost to bank conflicts |

## Verification
Each result is due at a cycle that the bench works out from the register indices alone. It computes N from the bank spread of the distinct enabled indices. Counting from the edge that accepts the request, `opnd_valid` must appear exactly at the (N+1)th falling edge, and the bench records the falling edge at which it first sees the pulse. At that same falling edge, the bench compares the operands, `req_ready` and the running conflict count against a model of the register contents and of the sum of N-1 over all requests. Requests offered while the block is busy are followed by several idle cycles in which no second pulse may appear.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic {
    PH_IDLE    = 1'b0,
    PH_COLLECT = 1'b1
  } phase_e;
endpackage

// File: rtl/oc_bank.sv
module oc_bank #(
  parameter int DATA_W = 32,
  parameter int ROWS   = 16,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem_q [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_row] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_row];
endmodule

// File: rtl/oc_arbiter.sv
module oc_arbiter #(
  parameter int NUM_SRC   = 3,
  parameter int NUM_BANKS = 4,
  parameter int IDX_W     = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROW_W    = IDX_W - BANK_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         pend,
  input  logic [NUM_SRC*IDX_W-1:0]   idx,
  output logic [NUM_SRC-1:0]         grant,
  output logic [NUM_BANKS*ROW_W-1:0] rd_row
);
  logic [NUM_BANKS-1:0] taken;

  // lowest pending slot in each bank wins that bank's port this cycle
  always_comb begin
    grant  = '0;
    taken  = '0;
    rd_row = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (pend[s] && !taken[b] &&
            (idx[s*IDX_W +: BANK_W] == BANK_W'(b))) begin
          grant[s]                = 1'b1;
          taken[b]                = 1'b1;
          rd_row[b*ROW_W +: ROW_W] = idx[s*IDX_W + BANK_W +: ROW_W];
        end
      end
    end
  end

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank_chk
    logic [NUM_SRC-1:0] hits;
    always_comb begin
      for (int s = 0; s < NUM_SRC; s++) begin
        hits[s] = grant[s] && (idx[s*IDX_W +: BANK_W] == BANK_W'(gb));
      end
    end
    // R3: a single-ported bank serves one slot per cycle
    assert_one_read_per_bank_R3: assert property (
      @(posedge clk) disable iff (!rst_n) $onehot0(hits));
  end
endmodule

// File: rtl/opnd_collector.sv
module opnd_collector
  import oc_pkg::*;
#(
  parameter int NUM_REGS  = 64,
  parameter int NUM_BANKS = 4,
  parameter int NUM_SRC   = 3,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROW_W    = IDX_W - BANK_W,
  localparam int ROWS     = NUM_REGS / NUM_BANKS,
  localparam int SLOT_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [NUM_SRC*IDX_W-1:0]  req_idx,
  input  logic [NUM_SRC-1:0]        req_en,
  output logic                      opnd_valid,
  output logic [NUM_SRC*DATA_W-1:0] opnd_data,
  output logic [CNT_W-1:0]          conflict_cnt
);
  phase_e                       phase_q, phase_n;
  logic [NUM_SRC-1:0]           pend_q, pend_n, pend_init, grant, pend_after;
  logic [NUM_SRC*IDX_W-1:0]     idx_q;
  logic [NUM_SRC-1:0]           en_q;
  logic [NUM_SRC-1:0][SLOT_W-1:0] prim_q, prim_n;
  logic [DATA_W-1:0]            cap_q [NUM_SRC];
  logic [NUM_SRC-1:0]           cap_en;
  logic                         vld_q, vld_n;
  logic [CNT_W-1:0]             cnt_q, cnt_n;
  logic                         accept, ctx_en;
  logic [NUM_BANKS*ROW_W-1:0]   rd_row;
  logic [DATA_W-1:0]            bank_rd [NUM_BANKS];

  // storage banks
  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en && (wr_idx[BANK_W-1:0] == BANK_W'(gb));
    oc_bank #(.DATA_W(DATA_W), .ROWS(ROWS)) u_bank (
      .clk     (clk),
      .wr_en   (bank_we),
      .wr_row  (wr_idx[IDX_W-1:BANK_W]),
      .wr_data (wr_data),
      .rd_row  (rd_row[gb*ROW_W +: ROW_W]),
      .rd_data (bank_rd[gb])
    );
  end

  oc_arbiter #(.NUM_SRC(NUM_SRC), .NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend   (pend_q),
    .idx    (idx_q),
    .grant  (grant),
    .rd_row (rd_row)
  );

  // duplicate folding: each slot points at the first enabled slot with its index
  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      prim_n[s] = SLOT_W'(s);
      for (int t = s - 1; t >= 0; t--) begin
        if (req_en[t] && req_en[s] &&
            (req_idx[t*IDX_W +: IDX_W] == req_idx[s*IDX_W +: IDX_W])) begin
          prim_n[s] = SLOT_W'(t);
        end
      end
      pend_init[s] = req_en[s] && (prim_n[s] == SLOT_W'(s));
    end
  end

  assign accept     = req_valid && (phase_q == PH_IDLE);
  assign ctx_en     = accept;
  assign pend_after = pend_q & ~grant;

  // next-state
  always_comb begin
    phase_n = phase_q;
    pend_n  = pend_q;
    vld_n   = 1'b0;
    cnt_n   = cnt_q;
    cap_en  = '0;
    if (accept) begin
      phase_n = PH_COLLECT;
      pend_n  = pend_init;
    end else if (phase_q == PH_COLLECT) begin
      pend_n = pend_after;
      cap_en = grant;
      if (pend_after == '0) begin
        phase_n = PH_IDLE;
        vld_n   = 1'b1;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pend_q  <= '0;
      vld_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_n;
      pend_q  <= pend_n;
      vld_q   <= vld_n;
      cnt_q   <= cnt_n;
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    if (ctx_en) begin
      idx_q  <= req_idx;
      en_q   <= req_en;
      prim_q <= prim_n;
    end
    for (int s = 0; s < NUM_SRC; s++) begin
      if (cap_en[s]) begin
        cap_q[s] <= bank_rd[idx_q[s*IDX_W +: BANK_W]];
      end
    end
  end

  // outputs in slot order
  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      opnd_data[s*DATA_W +: DATA_W] = en_q[s] ? cap_q[prim_q[s]] : '0;
    end
  end

  assign req_ready    = (phase_q == PH_IDLE);
  assign opnd_valid   = vld_q;
  assign conflict_cnt = cnt_q;

  // checks
  logic req_banks_apart;
  always_comb begin
    req_banks_apart = 1'b1;
    for (int s = 0; s < NUM_SRC; s++) begin
      for (int t = 0; t < s; t++) begin
        if (req_en[s] && req_en[t] &&
            (req_idx[s*IDX_W +: BANK_W] == req_idx[t*IDX_W +: BANK_W])) begin
          req_banks_apart = 1'b0;
        end
      end
    end
  end

  // R4: spread banks finish in one read cycle
  assert_single_pass_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_banks_apart) |-> ##2 opnd_valid);

  // R6: a request offered while busy does not disturb the latched instruction
  assert_busy_holds_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    (!req_ready && req_valid) |=> ($stable(idx_q) && $stable(en_q)));

  // R7: counter only moves during collection
  assert_cnt_idle_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> $stable(conflict_cnt));

  // R10: result is a one-cycle pulse
  assert_valid_pulse_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    opnd_valid |=> !opnd_valid);
endmodule

// File: tb/opnd_collector_tb.sv
module opnd_collector_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [5:0]  wr_idx;
  logic [31:0] wr_data;
  logic        req_valid;
  logic        req_ready;
  logic [17:0] req_idx;
  logic [2:0]  req_en;
  logic        opnd_valid;
  logic [95:0] opnd_data;
  logic [15:0] conflict_cnt;

  int total = 0;
  int bad = 0;
  int exp_cnt = 0;
  logic [31:0] model [64];

  always #5 clk = ~clk;

  opnd_collector u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx), .req_en(req_en),
    .opnd_valid(opnd_valid), .opnd_data(opnd_data), .conflict_cnt(conflict_cnt)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int calc_n(input int i0, input int i1, input int i2,
                                input logic [2:0] en);
    int ix [3];
    int n = 1;
    ix[0] = i0; ix[1] = i1; ix[2] = i2;
    for (int b = 0; b < 4; b++) begin
      int c = 0;
      for (int s = 0; s < 3; s++) begin
        bit dup = 0;
        for (int t = 0; t < s; t++) if (en[t] && ix[t] == ix[s]) dup = 1;
        if (en[s] && !dup && (ix[s] % 4) == b) c++;
      end
      if (c > n) n = c;
    end
    return n;
  endfunction

  task automatic write_reg(input int i, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'(i); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    model[i] = v;
  endtask

  task automatic load_all();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 6'(i);
      wr_data = {8'(i), 8'hC3, 8'(i * 7), 8'h5A};
      model[i] = wr_data;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_result(input int i0, input int i1, input int i2,
                              input logic [2:0] en, input int seen, input string tag);
    int ix [3];
    int n = calc_n(i0, i1, i2, en);
    ix[0] = i0; ix[1] = i1; ix[2] = i2;
    chk(seen == n + 1, tag, 64'(seen), 64'(n + 1));
    chk(req_ready == 1'b1, "R6", 64'(req_ready), 64'd1);
    for (int s = 0; s < 3; s++) begin
      logic [31:0] e = en[s] ? model[ix[s]] : 32'h0;
      // R8 slot order, R1 storage, R2 disabled zero
      chk(opnd_data[s*32 +: 32] == e, en[s] ? "R8" : "R2",
          64'(opnd_data[s*32 +: 32]), 64'(e));
    end
    exp_cnt += n - 1;
    chk(conflict_cnt == 16'(exp_cnt), "R7", 64'(conflict_cnt), 64'(exp_cnt));
  endtask

  task automatic run(input int i0, input int i1, input int i2,
                     input logic [2:0] en, input string tag);
    int seen = 1;
    @(negedge clk);
    req_valid = 1'b1;
    req_idx = {6'(i2), 6'(i1), 6'(i0)};
    req_en = en;
    @(negedge clk);
    req_valid = 1'b0;
    while (!opnd_valid && seen < 40) begin
      @(negedge clk);
      seen++;
    end
    check_result(i0, i1, i2, en, seen, tag);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R9", 64'(req_ready), 64'd1);
    chk(opnd_valid == 1'b0, "R9", 64'(opnd_valid), 64'd0);
    chk(conflict_cnt == 16'd0, "R9", 64'(conflict_cnt), 64'd0);
  endtask

  task automatic t_spread();
    run(6, 1, 3, 3'b111, "R4");
    run(0, 13, 30, 3'b111, "R4");
  endtask

  task automatic t_same_bank();
    run(4, 8, 12, 3'b111, "R3");
    run(5, 9, 2, 3'b111, "R3");
    run(63, 3, 19, 3'b111, "R3");
  endtask

  task automatic t_dup();
    run(7, 7, 11, 3'b111, "R5");
    run(10, 10, 10, 3'b111, "R5");
    run(20, 21, 20, 3'b111, "R5");
  endtask

  task automatic t_disabled();
    run(4, 8, 12, 3'b101, "R2");
    run(1, 2, 3, 3'b000, "R2");
    run(33, 17, 49, 3'b010, "R2");
  endtask

  task automatic t_rewrite();
    write_reg(44, 32'hDEAD_BEEF);
    write_reg(45, 32'h0BAD_F00D);
    run(44, 45, 40, 3'b111, "R1");
  endtask

  task automatic t_blocked();
    int seen = 1;
    @(negedge clk);
    req_valid = 1'b1;
    req_idx = {6'd12, 6'd8, 6'd4};
    req_en = 3'b111;
    @(negedge clk);
    chk(req_ready == 1'b0, "R6", 64'(req_ready), 64'd0);
    req_idx = {6'd3, 6'd2, 6'd1};
    req_en = 3'b111;
    @(negedge clk);
    seen++;
    req_valid = 1'b0;
    while (!opnd_valid && seen < 40) begin
      @(negedge clk);
      seen++;
    end
    check_result(4, 8, 12, 3'b111, seen, "R3");
    // R6 / R10: no further pulse from the ignored request
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(opnd_valid == 1'b0, "R6", 64'(opnd_valid), 64'd0);
    end
    chk(conflict_cnt == 16'(exp_cnt), "R7", 64'(conflict_cnt), 64'(exp_cnt));
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    req_valid = 1'b0; req_idx = '0; req_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    load_all();
    t_spread();
    t_same_bank();
    t_dup();
    t_disabled();
    t_rewrite();
    t_blocked();
    run(2, 6, 14, 3'b111, "R3");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule